// File: doc/BRIEF.md
# Programmable Divide-by-N+1 Pulse Divider

This block divides its clock by a run-time divisor. A presettable down counter counts from the divisor word `div_n` down to zero. Each time it reaches zero it reloads the word, so one cycle in every N+1 is a terminal cycle. On each terminal cycle a registered, active-low tick goes low for one clock. With an 8-bit word the ratio runs from 1/2 to 1/256.

The counter is built from `STAGES` identical slices of `STAGE_W` bits. A slice may decrement only when every slice below it is at zero. Two slices give a 16-bit divisor. The combined terminal count is a separate AND of all the slice zero flags and the enable, and it is never taken from the last slice alone. An active-low enable freezes the count. A new divisor word is only picked up at the next reload.

Top module: `divn_clkdiv`

## Requirements
- R1: While `rst` is high the counter is set to all ones and `tick_n` is high on the next cycle. With the enable asserted from release, the first low tick is sampled 2^W cycles after reset is released (W = `STAGE_W*STAGES`).
- R2: With divisor N ≥ 1 held and `en_n` low, falling edges of `tick_n` are exactly N+1 cycles apart. For example, N=1 gives 2 and N=3 gives 4.
- R3: For N ≥ 1 each low tick lasts exactly one clock cycle.
- R4: While `en_n` is high the count holds and `tick_n` stays high. When the enable returns, the current interval resumes and is lengthened by exactly the number of disabled cycles.
- R5: With N = 0 and the enable asserted, `tick_n` stays low on every cycle.
- R6: A new `div_n` value does not change the interval already in progress. It takes effect from the following reload.
- R7: N = 255 in the 8-bit configuration gives an interval of 256 cycles, the longest ratio.
- R8: With two slices, the 16-bit divisor gives intervals of N+1, including N = 256, where the low slice is zero at load.
- R9: On an enabled cycle the count drops by one when it is non-zero. On an enabled cycle at zero it reloads `div_n`, and the tick goes low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en_n | input | 1 | Count enable, active low |
| div_n | input | STAGE_W*STAGES | Divisor word N (ratio N+1) |
| tick_n | output | 1 | Registered terminal-count pulse, active low |

## Verification
The tick is registered behind the terminal decode. An enabled zero cycle therefore shows up as `tick_n` low one clock later. Intervals are measured between two low samples, and both samples carry that same one-cycle lag, so it cancels. All sampling is done on the falling clock edge, half a cycle after each rising edge. A new divisor word is applied just after a tick is seen. By then the reload for that tick has already happened, so the interval that follows must still use the old word and the one after it the new word. The disabled-window test counts the frozen cycles into the expected interval.

// File: rtl/divn_pkg.sv
package divn_pkg;
  localparam int DEF_STAGE_W = 8;

  typedef struct packed {
    logic load;
    logic dec;
  } stage_ctl_t;
endpackage

// File: rtl/divn_stage.sv
module divn_stage
  import divn_pkg::*;
#(
  parameter int W = DEF_STAGE_W
) (
  input  logic         clk,
  input  logic         rst,
  input  stage_ctl_t   ctl,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt,
  output logic         zero
);
  always_ff @(posedge clk) begin
    if (rst)           cnt <= '1;
    else if (ctl.load) cnt <= load_val;
    else if (ctl.dec)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/divn_tc_gate.sv
module divn_tc_gate #(
  parameter int N = 1
) (
  input  logic         en,
  input  logic [N-1:0] zeros,
  output logic [N:0]   carry,
  output logic         term
);
  assign carry[0] = en;
  for (genvar i = 0; i < N; i++) begin : g_chain
    assign carry[i+1] = carry[i] & zeros[i];
  end
  assign term = carry[N];
endmodule

// File: rtl/divn_clkdiv.sv
module divn_clkdiv
  import divn_pkg::*;
#(
  parameter int STAGE_W = DEF_STAGE_W,
  parameter int STAGES  = 1,
  localparam int W      = STAGE_W * STAGES
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_n,
  input  logic [W-1:0] div_n,
  output logic         tick_n
);
  logic              en;
  logic [STAGES-1:0] zeros;
  logic [STAGES:0]   carry;
  logic              term;
  logic [W-1:0]      cnt_all;

  assign en = ~en_n;

  divn_tc_gate #(.N(STAGES)) u_gate (
    .en    (en),
    .zeros (zeros),
    .carry (carry),
    .term  (term)
  );

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    stage_ctl_t ctl;
    assign ctl.load = term;
    assign ctl.dec  = carry[s] & ~term;

    divn_stage #(.W(STAGE_W)) u_stage (
      .clk      (clk),
      .rst      (rst),
      .ctl      (ctl),
      .load_val (div_n[s*STAGE_W +: STAGE_W]),
      .cnt      (cnt_all[s*STAGE_W +: STAGE_W]),
      .zero     (zeros[s])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) tick_n <= 1'b1;
    else     tick_n <= ~term;
  end
endmodule

// File: rtl/divn_clkdiv_chk.sv
module divn_clkdiv_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         en_n,
  input logic [W-1:0] div_n,
  input logic [W-1:0] cnt,
  input logic         tick_n
);
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (tick_n && cnt == '1));

  p_freeze_r4: assert property (@(posedge clk) disable iff (rst)
    en_n |=> (tick_n && $stable(cnt)));

  p_step_down_r9: assert property (@(posedge clk) disable iff (rst)
    (!en_n && cnt != '0) |=> (tick_n && cnt == $past(cnt) - 1'b1));

  p_reload_r9: assert property (@(posedge clk) disable iff (rst)
    (!en_n && cnt == '0) |=> (!tick_n && cnt == $past(div_n)));

  p_zero_div_low_r5: assert property (@(posedge clk) disable iff (rst)
    (!en_n && cnt == '0 && div_n == '0) |=> (!tick_n && cnt == '0));
endmodule

bind divn_clkdiv divn_clkdiv_chk #(.W(W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .en_n   (en_n),
  .div_n  (div_n),
  .cnt    (cnt_all),
  .tick_n (tick_n)
);

// File: tb/divn_clkdiv_bench.sv
module divn_clkdiv_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en_n = 1'b1;
  logic        en_n_w = 1'b1;
  logic [7:0]  div8 = 8'd3;
  logic [15:0] div16 = 16'd300;
  logic        tick8;
  logic        tick16;
  int          nchk = 0;
  int          nfail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  divn_clkdiv #(.STAGE_W(8), .STAGES(1)) u_divn_clkdiv (
    .clk(clk), .rst(rst), .en_n(en_n), .div_n(div8), .tick_n(tick8));

  divn_clkdiv #(.STAGE_W(8), .STAGES(2)) u_divn_clkdiv_wide (
    .clk(clk), .rst(rst), .en_n(en_n_w), .div_n(div16), .tick_n(tick16));

  function automatic int exp_gap(input int n);
    return n + 1;
  endfunction

  function automatic logic tk(input bit wide);
    return wide ? tick16 : tick8;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // counts falling-edge samples until tick is low; s1 = first sample taken
  task automatic next_low(input bit wide, output int c, output logic s1);
    c = 0;
    s1 = 1'b1;
    do begin
      @(negedge clk);
      c++;
      if (c == 1) s1 = tk(wide);
    end while (tk(wide) && c < 70000);
  endtask

  initial begin
    int g;
    logic s1;
    int r;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    check(tick8 == 1'b1, "R1 reset tick high", tick8, 1);
    rst = 1'b0;
    en_n = 1'b0;
    next_low(1'b0, g, s1);
    check(g == 256, "R1 first tick after reset", g, 256);

    next_low(1'b0, g, s1);
    check(g == exp_gap(3), "R2 N=3 interval", g, exp_gap(3));
    check(s1 == 1'b1, "R3 one-cycle pulse", s1, 1);

    div8 = 8'd1;
    next_low(1'b0, g, s1);
    check(g == exp_gap(3), "R6 old divisor holds", g, exp_gap(3));
    next_low(1'b0, g, s1);
    check(g == exp_gap(1), "R2 N=1 interval", g, exp_gap(1));
    check(s1 == 1'b1, "R3 pulse width N=1", s1, 1);

    div8 = 8'd255;
    next_low(1'b0, g, s1);
    next_low(1'b0, g, s1);
    check(g == exp_gap(255), "R7 N=255 interval", g, exp_gap(255));

    for (int k = 0; k < 5; k++) begin
      r = 1 + ($urandom % 255);
      div8 = r[7:0];
      next_low(1'b0, g, s1);
      next_low(1'b0, g, s1);
      check(g == exp_gap(r), "R2 random divisor", g, exp_gap(r));
    end

    div8 = 8'd20;
    next_low(1'b0, g, s1);
    repeat (3) @(negedge clk);
    en_n = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check(tick8 == 1'b1, "R4 tick high while disabled", tick8, 1);
    end
    en_n = 1'b0;
    next_low(1'b0, g, s1);
    check(g + 9 == exp_gap(20) + 6, "R4 interval stretched by pause", g + 9, exp_gap(20) + 6);

    div8 = 8'd0;
    repeat (300) @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      check(tick8 == 1'b0, "R5 N=0 stays low", tick8, 0);
    end

    rst = 1'b1;
    en_n_w = 1'b0;
    repeat (2) @(negedge clk);
    check(tick16 == 1'b1, "R1 wide reset tick high", tick16, 1);
    rst = 1'b0;
    next_low(1'b1, g, s1);
    check(g == 65536, "R1 R8 wide first tick", g, 65536);
    next_low(1'b1, g, s1);
    check(g == exp_gap(300), "R8 N=300 interval", g, exp_gap(300));
    check(s1 == 1'b1, "R3 wide pulse width", s1, 1);
    div16 = 16'd256;
    next_low(1'b1, g, s1);
    check(g == exp_gap(300), "R6 wide old divisor holds", g, exp_gap(300));
    next_low(1'b1, g, s1);
    check(g == exp_gap(256), "R8 N=256 interval", g, exp_gap(256));
    r = 257 + ($urandom % 2700);
    div16 = r[15:0];
    next_low(1'b1, g, s1);
    next_low(1'b1, g, s1);
    check(g == exp_gap(r), "R8 random wide divisor", g, exp_gap(r));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule